// File: doc/BRIEF.md
# Block-Scaled Microscaling Float Quantizer

This block takes a group of 32 single-precision floating-point numbers and turns it into one microscaled block. The block is one shared power-of-two exponent byte, unsigned and with no fraction bits, plus 32 narrow floating-point element codes. The exponent is derived from the largest-magnitude lane. Each lane is then divided by that power of two, rounded to nearest-even and saturated onto the grid of the chosen element format. Three element formats are available: 8-bit with 4 exponent and 3 mantissa bits, 8-bit with 5 exponent and 2 mantissa bits, and 4-bit with 2 exponent and 1 mantissa bit. In the 4-bit format a block costs 32 x 4 + 8 bits, which is 4.25 bits per element.

All 32 lanes are converted in one combinational stage. The stage has no memories and no multipliers. By default a single output register follows it. A parameter removes that register, and the outputs then follow the inputs combinationally.

Top module: `mx_block_quantizer`

## Requirements
- R1: After reset, `out_valid`, `out_scale` and `out_elems` are all zero. With the default registered output, `out_valid` in a cycle equals `in_valid` of the cycle before.
- R2: `out_scale` is found from the largest biased input exponent field E over the lanes that are neither Inf nor NaN. It is E minus 8 for fmt_sel 0, E minus 15 for fmt_sel 1, and E minus 2 for fmt_sel 2 or 3. Any negative result is clamped to 0.
- R3: `fmt_sel` encoding: 0 selects E4M3 (bias 7), 1 selects E5M2 (bias 15), and 2 or 3 selects E2M1 (bias 1). Lane i's code sits in `out_elems[8i+7:8i]`, right-aligned, with the sign bit directly above the exponent field. For E2M1 the upper four bits are zero.
- R4: Each element code is the input divided by 2^(out_scale-127), rounded to the nearest grid value of the selected format. A tie goes to the code with an even least significant bit.
- R5: A result above the largest finite element saturates to that element. The saturation codes are magnitude 0x7E (448) for E4M3, 0x7B (57344) for E5M2 and 0x7 (6.0) for E2M1. No NaN or Inf element code is ever produced.
- R6: A result below the smallest normal value becomes a subnormal code. A result at or below half the smallest subnormal becomes zero. The input sign bit is always copied to the element's sign bit.
- R7: An input with exponent field 0 (zero or subnormal) counts as zero. A block of positive zeros gives scale 0 and all-zero elements.
- R8: If any lane has exponent field 255 (Inf or NaN), `out_scale` is 0xFF and every element code is zero.
- R9: A cycle with `in_valid` low leaves `out_scale` and `out_elems` at their previous values, whatever `in_data` and `fmt_sel` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input block present |
| fmt_sel | input | 2 | Element format select |
| in_data | input | 1024 | 32 single-precision lanes, lane i at [32i+31:32i] |
| out_valid | output | 1 | Output block present |
| out_scale | output | 8 | Shared exponent, bias 127, 0xFF for a special block |
| out_elems | output | 256 | 32 element codes, lane i at [8i+7:8i] |

## Verification
The hardest situation to reach from the ports combines two effects in one block. The largest lane has a mantissa that rounds up past the top code of its format. At the same time the other lanes fall exactly on subnormal rounding ties or on the flush boundary. Random lane values almost never produce this mix.

The stimulus therefore builds these blocks directly. It fixes the largest lane's exponent and mantissa first, then places every other lane at an exact exponent offset below it. Random blocks drawn within a narrow exponent window around a moving base then cover the remaining mixes for every format.

// File: rtl/mxq_pkg.sv
package mxq_pkg;

  localparam int WORD_W = 32;
  localparam int CODE_W = 8;
  localparam int MANT_W = 23;

  // fmt_sel: 0 = E4M3, 1 = E5M2, 2/3 = E2M1
  function automatic int fmt_mbits(logic [1:0] f);
    case (f)
      2'd0:    return 3;
      2'd1:    return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int fmt_ebits(logic [1:0] f);
    case (f)
      2'd0:    return 4;
      2'd1:    return 5;
      default: return 2;
    endcase
  endfunction

  function automatic int fmt_bias(logic [1:0] f);
    case (f)
      2'd0:    return 7;
      2'd1:    return 15;
      default: return 1;
    endcase
  endfunction

  function automatic int fmt_emax(logic [1:0] f);
    case (f)
      2'd0:    return 8;
      2'd1:    return 15;
      default: return 2;
    endcase
  endfunction

  function automatic logic [7:0] fmt_maxmag(logic [1:0] f);
    case (f)
      2'd0:    return 8'h7E;
      2'd1:    return 8'h7B;
      default: return 8'h07;
    endcase
  endfunction

  function automatic int fmt_sign_pos(logic [1:0] f);
    return fmt_ebits(f) + fmt_mbits(f);
  endfunction

  // shared exponent byte from the block's largest exponent field
  function automatic logic [7:0] scale_code(logic [7:0] emax_in, logic [1:0] f);
    int t;
    t = int'(emax_in) - fmt_emax(f);
    if (t < 0) t = 0;
    return 8'(t);
  endfunction

  // right shift of a 24-bit significand with round-to-nearest-even
  function automatic int rne_shift(logic [23:0] m, int sh);
    logic [31:0] mm, q, rem, half;
    if (sh > 25) return 0;
    mm   = {8'd0, m};
    q    = mm >> sh;
    rem  = mm & ((32'd1 << sh) - 32'd1);
    half = 32'd1 << (sh - 1);
    return int'(q) + (((rem > half) || ((rem == half) && q[0])) ? 1 : 0);
  endfunction

  // one lane: normalise by the shared exponent, round, saturate
  function automatic logic [7:0] encode_lane(logic [31:0] x, logic [7:0] s, logic [1:0] f);
    int mb, be, mag;
    logic [7:0] r;
    mb = fmt_mbits(f);
    if (x[30:23] == 8'd0) begin
      mag = 0;
    end else begin
      be = int'(x[30:23]) - int'(s) + fmt_bias(f);
      if (be >= 1) mag = ((be - 1) << mb) + rne_shift({1'b1, x[22:0]}, MANT_W - mb);
      else         mag = rne_shift({1'b1, x[22:0]}, MANT_W + 1 - mb - be);
      if (mag > int'(fmt_maxmag(f))) mag = int'(fmt_maxmag(f));
    end
    r = 8'(mag);
    r[fmt_sign_pos(f)] = x[31];
    return r;
  endfunction

endpackage

// File: rtl/mxq_block_max.sv
module mxq_block_max
  import mxq_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [LANES*WORD_W-1:0] data,
  output logic [7:0]              max_exp,
  output logic                    any_special,
  output logic                    all_zero
);

  always_comb begin
    max_exp     = 8'd0;
    any_special = 1'b0;
    all_zero    = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (data[i*WORD_W+23 +: 8] == 8'hFF) any_special = 1'b1;
      else if (data[i*WORD_W+23 +: 8] > max_exp) max_exp = data[i*WORD_W+23 +: 8];
      if (data[i*WORD_W +: WORD_W] != '0) all_zero = 1'b0;
    end
  end

endmodule

// File: rtl/mxq_lane_enc.sv
module mxq_lane_enc
  import mxq_pkg::*;
(
  input  logic [WORD_W-1:0] x,
  input  logic [7:0]        scale,
  input  logic [1:0]        fmt,
  input  logic              force_zero,
  output logic [CODE_W-1:0] code
);

  always_comb begin
    if (force_zero) code = '0;
    else            code = encode_lane(x, scale, fmt);
  end

endmodule

// File: rtl/mx_block_quantizer.sv
module mx_block_quantizer
  import mxq_pkg::*;
#(
  parameter int LANES   = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              fmt_sel,
  input  logic [LANES*WORD_W-1:0] in_data,
  output logic                    out_valid,
  output logic [7:0]              out_scale,
  output logic [LANES*CODE_W-1:0] out_elems
);

  localparam int DATA_W = LANES * WORD_W;
  localparam int ELEM_W = LANES * CODE_W;

  // named internal events
  logic [7:0]        max_exp;
  logic              any_special;
  logic              all_zero;
  logic [7:0]        scale_c;
  logic [ELEM_W-1:0] elems_c;

  mxq_block_max #(.LANES(LANES)) u_max (
    .data        (in_data),
    .max_exp     (max_exp),
    .any_special (any_special),
    .all_zero    (all_zero)
  );

  assign scale_c = any_special ? 8'hFF : scale_code(max_exp, fmt_sel);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [CODE_W-1:0] code;
    logic [CODE_W-1:0] mag_w;

    mxq_lane_enc u_enc (
      .x          (in_data[i*WORD_W +: WORD_W]),
      .scale      (scale_c),
      .fmt        (fmt_sel),
      .force_zero (any_special),
      .code       (code)
    );

    assign elems_c[i*CODE_W +: CODE_W] = code;
    assign mag_w = code & ~(8'd1 << fmt_sign_pos(fmt_sel));

    // R2: the lane holding the block maximum never underflows when the scale is not clamped
    a_r2_max_lane_normal: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !any_special && (in_data[i*WORD_W+23 +: 8] == max_exp) &&
       (max_exp >= 8'(fmt_emax(fmt_sel))))
      |-> (mag_w >= (8'd1 << fmt_mbits(fmt_sel))));

    // R6: sign bit of a non-special lane follows the input sign
    a_r6_sign_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !any_special) |-> (code[fmt_sign_pos(fmt_sel)] == in_data[i*WORD_W+31]));
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        out_scale <= 8'd0;
        out_elems <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          out_scale <= scale_c;
          out_elems <= elems_c;
        end
      end
    end

    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid)));

    a_r8_special_block: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && any_special) |=> ((out_scale == 8'hFF) && (out_elems == '0)));

    a_r7_zero_block: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && all_zero) |=> ((out_scale == 8'd0) && (out_elems == '0)));

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_scale) && $stable(out_elems)));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_scale = scale_c;
    assign out_elems = elems_c;
  end

  logic unused_w;
  assign unused_w = ^{DATA_W[0]};

endmodule

// File: tb/mx_block_quantizer_tb_top.sv
module mx_block_quantizer_tb_top;

  localparam int LANES = 32;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  in_valid;
  logic [1:0]            fmt_sel;
  logic [LANES*32-1:0]   in_data;
  logic                  out_valid;
  logic [7:0]            out_scale;
  logic [LANES*8-1:0]    out_elems;

  mx_block_quantizer #(.LANES(LANES)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_sel(fmt_sel),
    .in_data(in_data), .out_valid(out_valid), .out_scale(out_scale), .out_elems(out_elems)
  );

  always #4 clk = ~clk;

  logic [LANES*32-1:0] stim;
  logic                exp_valid = 1'b0;
  logic [7:0]          exp_scale = 8'd0;
  logic [LANES*8-1:0]  exp_elems = '0;
  string               exp_tag = "R1";
  int                  n_chk = 0;
  int                  n_fail = 0;
  bit                  done = 1'b0;

  function automatic real p2(int n);
    real r = 1.0;
    if (n >= 0) for (int k = 0; k < n; k++) r = r * 2.0;
    else        for (int k = 0; k < -n; k++) r = r / 2.0;
    return r;
  endfunction

  function automatic real f32(logic [31:0] w);
    real v;
    if (w[30:23] == 8'd0 || w[30:23] == 8'hFF) return 0.0;
    v = (1.0 + real'(w[22:0]) / 8388608.0) * p2(int'(w[30:23]) - 127);
    return w[31] ? -v : v;
  endfunction

  function automatic real dec_el(int c, int mb, int bias);
    int e = c >> mb;
    int f = c & ((1 << mb) - 1);
    if (e == 0) return real'(f) / p2(mb) * p2(1 - bias);
    return (1.0 + real'(f) / p2(mb)) * p2(e - bias);
  endfunction

  task automatic ref_model(input logic [1:0] f, output logic [7:0] sc, output logic [LANES*8-1:0] el);
    int mb, eb, bias, emx, mx, k, s, best;
    real mxabs, v, d, bd;
    bit special = 1'b0;
    case (f)
      2'd0:    begin mb = 3; eb = 4; bias = 7;  emx = 8;  mx = 126; end
      2'd1:    begin mb = 2; eb = 5; bias = 15; emx = 15; mx = 123; end
      default: begin mb = 1; eb = 2; bias = 1;  emx = 2;  mx = 7;   end
    endcase
    el = '0;
    mxabs = 0.0;
    for (int i = 0; i < LANES; i++) begin
      if (stim[i*32+23 +: 8] == 8'hFF) special = 1'b1;
      v = f32(stim[i*32 +: 32]);
      if (v < 0.0) v = -v;
      if (v > mxabs) mxabs = v;
    end
    if (special) begin sc = 8'hFF; return; end
    if (mxabs == 0.0) k = -127;
    else begin
      k = -126;
      while (p2(k + 1) <= mxabs) k++;
    end
    s = k + 127 - emx;
    if (s < 0) s = 0;
    sc = 8'(s);
    for (int i = 0; i < LANES; i++) begin
      v = f32(stim[i*32 +: 32]);
      if (v < 0.0) v = -v;
      v = v * p2(127 - s);
      best = 0; bd = v;
      for (int c = 1; c <= mx; c++) begin
        d = v - dec_el(c, mb, bias);
        if (d < 0.0) d = -d;
        if (d < bd || (d == bd && (best % 2 == 1) && (c % 2 == 0))) begin best = c; bd = d; end
      end
      el[i*8 +: 8] = 8'(best) | (8'(stim[i*32+31]) << (eb + mb));
    end
  endtask

  task automatic chk(bit ok, string tag, string what, logic [255:0] act, logic [255:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic compare();
    chk(out_valid == exp_valid, exp_tag, "out_valid", 256'(out_valid), 256'(exp_valid));
    chk(out_scale == exp_scale, exp_tag, "out_scale", 256'(out_scale), 256'(exp_scale));
    chk(out_elems == exp_elems, exp_tag, "out_elems", 256'(out_elems), 256'(exp_elems));
  endtask

  task automatic cycle(bit v, logic [1:0] f, string tag);
    logic [7:0] s;
    logic [LANES*8-1:0] e;
    @(negedge clk);
    compare();
    in_valid = v; fmt_sel = f; in_data = stim;
    if (v) begin
      ref_model(f, s, e);
      exp_valid = 1'b1; exp_scale = s; exp_elems = e; exp_tag = tag;
    end else begin
      exp_valid = 1'b0; exp_tag = "R9";
    end
  endtask

  function automatic logic [31:0] mk(bit sg, int e, int fr);
    return {sg, 8'(e), 23'(fr)};
  endfunction

  task automatic fill(int base, int spread);
    for (int i = 0; i < LANES; i++) begin
      int e = base - int'($urandom % spread);
      if (e < 0) e = 0;
      if ($urandom % 16 == 0) e = 0;
      stim[i*32 +: 32] = mk(1'($urandom), e, int'($urandom % 8388608));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; fmt_sel = 2'd0; in_data = '0; stim = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state is checked by the first compare
    // R2 R3: a uniform block in every format
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < LANES; i++) stim[i*32 +: 32] = mk(0, 127, 0);
      cycle(1'b1, 2'(f), (f == 3) ? "R3" : "R2");
    end
    // R4: mantissa patterns with ties around one maximum
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < LANES; i++) stim[i*32 +: 32] = mk(i[0], 126, i << 18);
      stim[31:0] = mk(0, 128, 0);
      cycle(1'b1, 2'(f), "R4");
    end
    // R5: maximum lane rounds past the top code
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < LANES; i++) stim[i*32 +: 32] = mk(i[1], 140, 23'h7FFFFF - i);
      cycle(1'b1, 2'(f), "R5");
    end
    // R6: subnormal results, ties and flush to signed zero
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < LANES; i++) stim[i*32 +: 32] = mk(i[0], 129 - i, (i % 3) << 21);
      stim[31:0] = mk(0, 129, 0);
      cycle(1'b1, 2'(f), "R6");
    end
    for (int i = 0; i < LANES; i++) stim[i*32 +: 32] = mk(1, 126, 23'h400000);
    stim[31:0] = mk(0, 129, 0);
    stim[63:32] = mk(0, 125, 0);
    cycle(1'b1, 2'd2, "R6");
    // R7: zero block and subnormal-only block
    stim = '0;
    cycle(1'b1, 2'd0, "R7");
    for (int i = 0; i < LANES; i++) stim[i*32 +: 32] = mk(0, 0, i + 1);
    cycle(1'b1, 2'd1, "R7");
    // R2: tiny block clamps the scale at 0
    for (int i = 0; i < LANES; i++) stim[i*32 +: 32] = mk(i[2], 3, i << 15);
    cycle(1'b1, 2'd1, "R2");
    // R8: NaN and Inf lanes
    fill(130, 10); stim[17*32 +: 32] = 32'h7FC00001;
    cycle(1'b1, 2'd0, "R8");
    fill(130, 10); stim[3*32 +: 32] = 32'hFF800000;
    cycle(1'b1, 2'd2, "R8");
    // R9: idle cycles with changing inputs
    for (int n = 0; n < 4; n++) begin
      fill(150, 20);
      cycle(1'b0, 2'(n), "R9");
    end
    // R4 R5 R6: random blocks, mixed formats and gaps
    for (int n = 0; n < 400; n++) begin
      fill(20 + int'($urandom % 220), 4 + int'($urandom % 30));
      cycle(($urandom % 5) != 0, 2'($urandom), "R4");
    end
    cycle(1'b0, 2'd0, "R9");
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule